// File: doc/BRIEF.md
# Four-Lane Partial-Response Level Shaper

This block sits at the end of a four-pair transmit symbol path. On each symbol clock it takes one signed five-level symbol per lane, in the range −2..+2. For every lane it forms a shaped level that mixes the new symbol with the symbol that lane carried before it. The weights are three quarters for the current symbol and one quarter for the previous one. Applying these weights to the five-level alphabet moves transmit energy out of the 30–60 MHz band. It also yields exactly seventeen distinct output levels.

Each shaped level is given as the signed integer 3·x(k) + x(k−1), which is in quarter units. It lies in −8..+8 and fits a 5-bit two's-complement field that a downstream converter lookup can index directly. Each lane keeps its own one-symbol history.

Codes outside the legal range are replaced by zero and latch a per-lane error flag. A bypass input drops the shaping and outputs the scaled current symbol 4·x(k), so the path can be tested without shaping. Results appear one cycle after the symbols, and the input qualifier is delayed to match.

Top module: `prs_pam17_enc`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, level_out, out_valid and sym_err are all zero. The history of every lane is zero, so the first valid symbol x after reset gives the level 3·x.
- R2: Each lane i takes a 3-bit two's-complement symbol from sym_in[3i+2:3i]. One cycle after a cycle with in_valid high and bypass low, level_out[5i+4:5i] holds 3·x(k) + x(k−1) as 5-bit two's complement. Here x(k−1) is the lane's symbol from the previous valid cycle.
- R3: Every level is within −8..+8. Going through all 25 pairs of legal previous and current symbols produces exactly 17 distinct levels.
- R4: The history register of a lane takes a new symbol only on cycles where in_valid is high. Cycles with in_valid low between two valid symbols do not change the pairing.
- R5: out_valid equals in_valid from one cycle earlier. After a cycle with in_valid low, level_out keeps its previous value.
- R6: An input code of +3, −3 or −4 on a valid cycle is used as 0, both in that cycle's level and in the history. It sets that lane's bit of sym_err, which stays set until reset.
- R7: One cycle after a cycle with in_valid and bypass both high, each lane outputs 4·x(k). The history still takes x(k), so the next shaped cycle uses it as x(k−1).
- R8: The lanes are independent: a symbol on one lane does not affect the level, history or error flag of any other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Symbols on sym_in are valid this cycle |
| bypass | input | 1 | Output 4·x(k) instead of the shaped level |
| sym_in | input | LANES*SYM_W (12) | One signed symbol per lane, lane i at [3i+2:3i] |
| level_out | output | LANES*LVL_W (20) | One signed level per lane, lane i at [5i+4:5i] |
| out_valid | output | 1 | level_out was updated from a valid input cycle |
| sym_err | output | LANES (4) | Sticky per-lane flag for an out-of-range code |

## Verification
A directed sweep drives every ordered pair of legal symbols on one lane. This separates the correct 3:1 weighting from swapped or equal weights, and shows the seventeen-level set. Random traffic with a fixed seed mixes idle gaps, bypass cycles and the three illegal codes on all lanes. A bench model follows it: the gaps reveal history that is updated without qualification, and the bypass-then-shaped sequences reveal history that is frozen during bypass. Different symbols on neighbouring lanes expose any crosstalk in lane slicing. The illegal codes show whether substitution and error latching happen.

// File: rtl/prs_pkg.sv
// Shared constants for the partial-response level shaper.
// Assumes symbols in the range -2..+2 and levels in quarter units.
package prs_pkg;
    localparam int PRS_SYM_W = 3;   // signed symbol field width
    localparam int PRS_LVL_W = 5;   // signed level field width
    localparam int PRS_SYM_MAX = 2; // largest legal symbol magnitude
    localparam int PRS_CUR_WT = 3;  // weight of the current symbol
    localparam int PRS_BYP_WT = 4;  // scale used in bypass
endpackage

// File: rtl/prs_sym_screen.sv
// Range screen for one symbol: flags any code outside the legal range
// and replaces it with zero. Purely combinational.
module prs_sym_screen #(
    parameter int SYM_W = prs_pkg::PRS_SYM_W,
    parameter int SYM_MAX = prs_pkg::PRS_SYM_MAX
) (
    input  logic signed [SYM_W-1:0] code_in,
    output logic signed [SYM_W-1:0] code_out,
    output logic                    illegal
);
    // Compare in integer range, then substitute zero when out of range.
    always_comb begin
        illegal  = (int'(code_in) > SYM_MAX) || (int'(code_in) < -SYM_MAX);
        code_out = illegal ? '0 : code_in;
    end
endmodule

// File: rtl/prs_lane.sv
// One lane of the shaper: screen, history register, weighted sum and
// registered output. Assumes LVL_W is wide enough for 4*SYM_MAX.
module prs_lane #(
    parameter int SYM_W = prs_pkg::PRS_SYM_W,
    parameter int LVL_W = prs_pkg::PRS_LVL_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    bypass,
    input  logic signed [SYM_W-1:0] sym,
    output logic signed [LVL_W-1:0] level,
    output logic                    err
);
    localparam int EXT_W = LVL_W - SYM_W;

    logic signed [SYM_W-1:0] clean;
    logic                    illegal;
    logic signed [SYM_W-1:0] hist_q;
    logic signed [LVL_W-1:0] cur_e, hist_e, shaped, scaled;

    prs_sym_screen #(.SYM_W(SYM_W)) u_screen (
        .code_in  (sym),
        .code_out (clean),
        .illegal  (illegal)
    );

    // Sign-extend and form the shaped and bypass levels.
    always_comb begin
        cur_e  = {{EXT_W{clean[SYM_W-1]}}, clean};
        hist_e = {{EXT_W{hist_q[SYM_W-1]}}, hist_q};
        shaped = (cur_e <<< 1) + cur_e + hist_e;
        scaled = cur_e <<< 2;
    end

    // History, output level and sticky error, all qualified by in_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            level  <= '0;
            err    <= 1'b0;
        end else if (in_valid) begin
            hist_q <= clean;
            level  <= bypass ? scaled : shaped;
            if (illegal) err <= 1'b1;
        end
    end
endmodule

// File: rtl/prs_pam17_enc.sv
// Four-lane partial-response shaper top. It slices the packed symbol
// bus into lanes, builds one lane per slice, and delays the valid flag
// by one cycle to match the registered levels.
module prs_pam17_enc #(
    parameter int LANES = 4,
    parameter int SYM_W = prs_pkg::PRS_SYM_W,
    parameter int LVL_W = prs_pkg::PRS_LVL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   bypass,
    input  logic [LANES*SYM_W-1:0] sym_in,
    output logic [LANES*LVL_W-1:0] level_out,
    output logic                   out_valid,
    output logic [LANES-1:0]       sym_err
);
    // One lane instance per packed slice.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [LVL_W-1:0] lvl;
        prs_lane #(.SYM_W(SYM_W), .LVL_W(LVL_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid),
            .bypass   (bypass),
            .sym      (sym_in[i*SYM_W +: SYM_W]),
            .level    (lvl),
            .err      (sym_err[i])
        );
        assign level_out[i*LVL_W +: LVL_W] = lvl;
    end

    // Delay the input qualifier to line up with the level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end
endmodule

// File: rtl/prs_chk.sv
// Assertion checker for the shaper, bound to the top module.
module prs_chk #(
    parameter int LANES = 4,
    parameter int SYM_W = 3,
    parameter int LVL_W = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   bypass,
    input logic [LANES*SYM_W-1:0] sym_in,
    input logic [LANES*LVL_W-1:0] level_out,
    input logic                   out_valid,
    input logic [LANES-1:0]       sym_err
);
    // R5
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R5
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(level_out));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_err & $past(sym_err)) == $past(sym_err));

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        // R3
        lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(level_out[i*LVL_W +: LVL_W]) <= 8) &&
            ($signed(level_out[i*LVL_W +: LVL_W]) >= -8));

        // R7
        byp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && bypass) |=> (level_out[i*LVL_W +: 2] == 2'b00));
    end
endmodule

bind prs_pam17_enc prs_chk #(.LANES(LANES), .SYM_W(SYM_W), .LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .bypass    (bypass),
    .sym_in    (sym_in),
    .level_out (level_out),
    .out_valid (out_valid),
    .sym_err   (sym_err)
);

// File: tb/prs_pam17_enc_tb.sv
module prs_pam17_enc_tb;
    localparam int LANES = 4;
    localparam int SW = 3;
    localparam int LW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic bypass = 1'b0;
    logic [LANES*SW-1:0] sym_in = '0;
    logic [LANES*LW-1:0] level_out;
    logic out_valid;
    logic [LANES-1:0] sym_err;

    int checks = 0;
    int failures = 0;
    int hist_m [LANES];
    int lvl_m [LANES];
    logic [LANES-1:0] err_m;
    logic [16:0] seen;
    bit done = 1'b0;

    prs_pam17_enc u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bypass(bypass),
        .sym_in(sym_in), .level_out(level_out), .out_valid(out_valid),
        .sym_err(sym_err)
    );

    always #2 clk = ~clk;

    function automatic int sym_of(logic [SW-1:0] c);
        return int'($signed(c));
    endfunction

    function automatic bit is_legal(int x);
        return (x >= -2) && (x <= 2);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare(string req);
        for (int i = 0; i < LANES; i++) begin
            int a;
            a = int'($signed(level_out[i*LW +: LW]));
            check(a == lvl_m[i], req, a, lvl_m[i]);
        end
        check(sym_err == err_m, "R6 err", int'(sym_err), int'(err_m));
    endtask

    // Drive one cycle at the falling edge, then update the model and compare.
    task automatic apply(bit v, bit b, logic [LANES*SW-1:0] s, string req);
        @(negedge clk);
        in_valid = v; bypass = b; sym_in = s;
        @(posedge clk); #1;
        if (v) begin
            for (int i = 0; i < LANES; i++) begin
                int x;
                x = sym_of(s[i*SW +: SW]);
                if (!is_legal(x)) begin x = 0; err_m[i] = 1'b1; end
                lvl_m[i] = b ? 4 * x : 3 * x + hist_m[i];
                hist_m[i] = x;
            end
        end
        check(out_valid == v, "R5 out_valid", int'(out_valid), int'(v));
        compare(req);
    endtask

    function automatic logic [LANES*SW-1:0] pack1(int lane, int x);
        logic [LANES*SW-1:0] r = '0;
        r[lane*SW +: SW] = SW'(x);
        return r;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < LANES; i++) begin hist_m[i] = 0; lvl_m[i] = 0; end
        err_m = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        compare("R1 level");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        compare("R1 level after release");
        // R1: first symbol after reset sees zero history
        apply(1'b1, 1'b0, pack1(1, 2) | pack1(2, -1), "R1 first");
        // R3: sweep all ordered pairs on lane 0, collect levels
        seen = '0;
        for (int p = -2; p <= 2; p++) begin
            for (int c = -2; c <= 2; c++) begin
                apply(1'b1, 1'b0, pack1(0, p), "R2 sweep");
                apply(1'b1, 1'b0, pack1(0, c), "R2 sweep");
                seen[int'($signed(level_out[LW-1:0])) + 8] = 1'b1;
            end
        end
        check($countones(seen) == 17, "R3 distinct", $countones(seen), 17);
        // R4: gap between valid symbols keeps the pairing
        apply(1'b1, 1'b0, pack1(0, 2) | pack1(3, -2), "R4 pre");
        apply(1'b0, 1'b0, pack1(0, -2) | pack1(3, 1), "R4 gap");
        apply(1'b0, 1'b1, pack1(0, 1), "R5 hold");
        apply(1'b1, 1'b0, pack1(0, 1) | pack1(3, 1), "R4 after gap");
        // R7: bypass output then shaped use of the bypassed history
        apply(1'b1, 1'b1, pack1(0, -2) | pack1(2, 2), "R7 bypass");
        apply(1'b1, 1'b0, pack1(0, 1) | pack1(2, 0), "R7 after bypass");
        // R6: illegal codes on separate lanes
        apply(1'b0, 1'b0, pack1(1, 3), "R6 not valid");
        apply(1'b1, 1'b0, pack1(1, 3), "R6 illegal +3");
        apply(1'b1, 1'b0, pack1(1, 2) | pack1(2, -4), "R6 illegal -4");
        // R8: distinct patterns on every lane
        apply(1'b1, 1'b0, pack1(0, 2) | pack1(1, -2) | pack1(2, 1) | pack1(3, -1), "R8 lanes");
        // Random traffic, mostly legal codes
        for (int n = 0; n < 400; n++) begin
            logic [LANES*SW-1:0] s;
            for (int i = 0; i < LANES; i++) begin
                if (($urandom % 10) < 8) s[i*SW +: SW] = SW'(int'($urandom % 5) - 2);
                else s[i*SW +: SW] = SW'($urandom);
            end
            apply(($urandom % 4) != 0, ($urandom % 6) == 0, s, "R2 random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule